// File: doc/BRIEF.md
# Auto-Increment Two-Wire Register Slave

This block lets a host microcontroller reach a bank of byte-wide control registers and a small window of read-only status bytes over a two-wire serial bus. It watches the clock and data lines and recognises start and stop conditions. It shifts bytes in and out most significant bit first and answers only to its own device address. After the address it takes a one-byte register pointer. Each data byte that follows is written to the location the pointer selects, and the pointer then steps by one. The number of bytes in a transfer has no limit.

A read begins with a write that carries only the pointer byte. The host then sends a stop, a new start and the read address. The slave drives each bit by pulling the line low or letting it float. After every byte it releases the line to sample the host's acknowledge. The pointer is kept between transfers and is shared by reads and writes. The writable registers sit in an external register file. The slave reaches them through a write strobe and a combinational read port. The status bytes come in as one packed input vector.

Top module: `i2c_regbank_slave`

## Requirements
- R1: After reset the slave releases SDA, issues no write strobe and holds a pointer of 00h, so a read started without a pointer write returns the byte at address 00h.
- R2: An address byte other than 24h (write) or 25h (read) gets no acknowledge. The slave then ignores every following byte until the next start: it drives nothing and writes nothing.
- R3: In a write transfer each byte after the address is acknowledged by a low in the ninth clock. The first of them loads the pointer. Each later byte raises `wr_en_o` for one clock, with `wr_addr_o` equal to the pointer and `wr_data_o` equal to the byte, and the pointer then steps by one.
- R4: Data bytes sent to pointer values 1Fh and above are still acknowledged and still step the pointer, but they produce no write strobe.
- R5: After address 25h is acknowledged, the slave sends the byte at the pointer MSB first. For pointer values below 1Fh the byte comes from `rd_data_i` while `rd_addr_o` equals the pointer.
- R6: Pointer values 1Fh to 24h read status byte k = pointer − 1Fh, which is `status_i[8k+7:8k]`.
- R7: Pointer values above 24h read as 00h.
- R8: After each read byte the slave releases SDA for the acknowledge clock. A host low there makes it send the next byte from the stepped pointer. A host high ends the read, and SDA then stays released until the next start.
- R9: A stop, even in the middle of a byte, returns the slave to idle with SDA released. A partly received byte is never written.
- R10: A start received during a transfer (repeated start) begins a new address phase, and the pointer keeps its value.
- R11: The pointer keeps its value across a stop, so a later read continues at the address after the last byte written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_pull_o | output | 1 | High to pull the data line low (open drain) |
| wr_en_o | output | 1 | One-clock write strobe to the register file |
| wr_addr_o | output | 8 | Register address for the write |
| wr_data_o | output | 8 | Byte to write |
| rd_addr_o | output | 8 | Current pointer, presented to the register file read port |
| rd_data_i | input | 8 | Register file byte at `rd_addr_o` |
| status_i | input | 48 | Six read-only status bytes, byte k at bits 8k+7:8k |

## Verification
An error in the bit counter or the protocol state shows up on the bus within one byte. It appears as an acknowledge in the wrong clock, a missing acknowledge, or a read byte shifted by a bit, and any of these shows in the next value the host samples. An error in the pointer or the address decode shows up as a wrong byte in a read burst, or as a write strobe with a wrong address or a missing one. The long read sweep that crosses the edge between writable, status and unmapped addresses therefore locates such an error to one address. A slave that fails to go idle after a mismatched address or a host not-acknowledge shows up as a low on a line the host expects to stay high.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK
    } i2cs_state_e;

    // Line events seen on the synchronised bus signals
    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } line_ev_t;

    function automatic logic dev_match(input logic [7:0] addr_byte, input logic [6:0] dev7);
        return addr_byte[7:1] == dev7;
    endfunction

endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync
    import i2cs_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev_o
);
    logic [1:0] scl_pipe, sda_pipe;
    logic       scl_d, sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= 2'b11;
            sda_pipe <= 2'b11;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[0], scl_i};
            sda_pipe <= {sda_pipe[0], sda_i};
            scl_d    <= scl_pipe[1];
            sda_d    <= sda_pipe[1];
        end
    end

    always_comb begin
        ev_o.scl      = scl_pipe[1];
        ev_o.sda      = sda_pipe[1];
        ev_o.scl_rise = scl_pipe[1] & ~scl_d;
        ev_o.scl_fall = ~scl_pipe[1] & scl_d;
        ev_o.start    = scl_pipe[1] & scl_d & sda_d & ~sda_pipe[1];
        ev_o.stop     = scl_pipe[1] & scl_d & ~sda_d & sda_pipe[1];
    end
endmodule

// File: rtl/i2cs_read_mux.sv
module i2cs_read_mux #(
    parameter int NUM_RW     = 31,
    parameter int NUM_STATUS = 6
) (
    input  logic [7:0]              ptr_i,
    input  logic [7:0]              rd_data_i,
    input  logic [8*NUM_STATUS-1:0] status_i,
    output logic [7:0]              byte_o
);
    localparam logic [7:0] RW_END = 8'(NUM_RW);

    always_comb begin
        byte_o = 8'h00;
        if (ptr_i < RW_END) byte_o = rd_data_i;
        for (int k = 0; k < NUM_STATUS; k++) begin
            if (ptr_i == 8'(NUM_RW + k)) byte_o = status_i[8*k +: 8];
        end
    end
endmodule

// File: rtl/i2cs_proto.sv
module i2cs_proto
    import i2cs_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR7 = 7'h12,
    parameter int         NUM_RW    = 31
) (
    input  logic       clk,
    input  logic       rst,
    input  line_ev_t   ev_i,
    input  logic [7:0] rd_byte_i,
    output logic [7:0] ptr_o,
    output logic       sda_pull_o,
    output logic       wr_en_o,
    output logic [7:0] wr_addr_o,
    output logic [7:0] wr_data_o
);
    localparam logic [7:0] RW_END = 8'(NUM_RW);

    i2cs_state_e state;
    logic [3:0]  bitcnt;
    logic [7:0]  shreg;
    logic [7:0]  ptr;
    logic        is_read;
    logic        host_ack;

    assign ptr_o = ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            bitcnt     <= '0;
            shreg      <= '0;
            ptr        <= '0;
            is_read    <= 1'b0;
            host_ack   <= 1'b0;
            sda_pull_o <= 1'b0;
            wr_en_o    <= 1'b0;
            wr_addr_o  <= '0;
            wr_data_o  <= '0;
        end else begin
            wr_en_o <= 1'b0;
            if (ev_i.start) begin
                state      <= ST_ADDR;
                bitcnt     <= '0;
                sda_pull_o <= 1'b0;
            end else if (ev_i.stop) begin
                state      <= ST_IDLE;
                sda_pull_o <= 1'b0;
            end else begin
                unique case (state)
                    ST_ADDR, ST_PTR, ST_WDATA: begin
                        if (ev_i.scl_rise && bitcnt < 4'd8) begin
                            shreg  <= {shreg[6:0], ev_i.sda};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (ev_i.scl_fall && bitcnt == 4'd8) begin
                            bitcnt <= '0;
                            if (state == ST_ADDR) begin
                                if (dev_match(shreg, DEV_ADDR7)) begin
                                    is_read    <= shreg[0];
                                    sda_pull_o <= 1'b1;
                                    state      <= ST_ADDR_ACK;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else if (state == ST_PTR) begin
                                ptr        <= shreg;
                                sda_pull_o <= 1'b1;
                                state      <= ST_PTR_ACK;
                            end else begin
                                wr_en_o    <= (ptr < RW_END);
                                wr_addr_o  <= ptr;
                                wr_data_o  <= shreg;
                                ptr        <= ptr + 8'd1;
                                sda_pull_o <= 1'b1;
                                state      <= ST_WDATA_ACK;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (ev_i.scl_fall) begin
                            if (is_read) begin
                                shreg      <= rd_byte_i;
                                sda_pull_o <= ~rd_byte_i[7];
                                state      <= ST_RDATA;
                            end else begin
                                sda_pull_o <= 1'b0;
                                state      <= ST_PTR;
                            end
                        end
                    end
                    ST_PTR_ACK, ST_WDATA_ACK: begin
                        if (ev_i.scl_fall) begin
                            sda_pull_o <= 1'b0;
                            state      <= ST_WDATA;
                        end
                    end
                    ST_RDATA: begin
                        if (ev_i.scl_fall) begin
                            if (bitcnt == 4'd7) begin
                                bitcnt     <= '0;
                                sda_pull_o <= 1'b0;
                                ptr        <= ptr + 8'd1;
                                state      <= ST_RACK;
                            end else begin
                                bitcnt     <= bitcnt + 4'd1;
                                shreg      <= {shreg[6:0], 1'b0};
                                sda_pull_o <= ~shreg[6];
                            end
                        end
                    end
                    ST_RACK: begin
                        if (ev_i.scl_rise) host_ack <= ~ev_i.sda;
                        if (ev_i.scl_fall) begin
                            if (host_ack) begin
                                shreg      <= rd_byte_i;
                                sda_pull_o <= ~rd_byte_i[7];
                                state      <= ST_RDATA;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // R1
    reset_release_chk: assert property (@(posedge clk) rst |=> (!sda_pull_o && !wr_en_o));

    // R2
    start_release_chk: assert property (@(posedge clk) disable iff (rst)
        ev_i.start |=> !sda_pull_o);

    // R9
    stop_release_chk: assert property (@(posedge clk) disable iff (rst)
        ev_i.stop |=> !sda_pull_o);

    // R3
    single_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |=> !wr_en_o);

    // R8
    drive_on_low_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_pull_o) |-> !ev_i.scl);
endmodule

// File: rtl/i2c_regbank_slave.sv
module i2c_regbank_slave
    import i2cs_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR7  = 7'h12,
    parameter int         NUM_RW     = 31,
    parameter int         NUM_STATUS = 6
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    scl_i,
    input  logic                    sda_i,
    output logic                    sda_pull_o,
    output logic                    wr_en_o,
    output logic [7:0]              wr_addr_o,
    output logic [7:0]              wr_data_o,
    output logic [7:0]              rd_addr_o,
    input  logic [7:0]              rd_data_i,
    input  logic [8*NUM_STATUS-1:0] status_i
);
    line_ev_t   ev;
    logic [7:0] ptr;
    logic [7:0] rd_byte;

    assign rd_addr_o = ptr;

    i2cs_line_sync u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev_o  (ev)
    );

    i2cs_read_mux #(
        .NUM_RW     (NUM_RW),
        .NUM_STATUS (NUM_STATUS)
    ) u_rmux (
        .ptr_i     (ptr),
        .rd_data_i (rd_data_i),
        .status_i  (status_i),
        .byte_o    (rd_byte)
    );

    i2cs_proto #(
        .DEV_ADDR7 (DEV_ADDR7),
        .NUM_RW    (NUM_RW)
    ) u_proto (
        .clk        (clk),
        .rst        (rst),
        .ev_i       (ev),
        .rd_byte_i  (rd_byte),
        .ptr_o      (ptr),
        .sda_pull_o (sda_pull_o),
        .wr_en_o    (wr_en_o),
        .wr_addr_o  (wr_addr_o),
        .wr_data_o  (wr_data_o)
    );
endmodule

// File: tb/i2c_regbank_slave_bench.sv
module i2c_regbank_slave_bench;
    localparam int NRW = 31;
    localparam int NST = 6;
    localparam int Q   = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic h_scl = 1'b1;
    logic h_sda = 1'b1;
    logic sda_pull, wr_en;
    logic [7:0] wr_addr, wr_data, rd_addr, rd_data;
    logic [8*NST-1:0] status;
    logic sda_line;

    logic [7:0] rf    [NRW];
    logic [7:0] model [NRW];
    int wr_cnt = 0;
    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    assign sda_line = h_sda & ~sda_pull;
    assign rd_data  = (rd_addr < 8'(NRW)) ? rf[rd_addr[4:0]] : 8'h00;

    function automatic logic [7:0] stat_byte(int k);
        return 8'(8'h90 + k * 8'h13);
    endfunction

    always_comb for (int k = 0; k < NST; k++) status[8*k +: 8] = stat_byte(k);

    function automatic logic [7:0] exp_read(int a);
        if (a < NRW) return model[a];
        if (a < NRW + NST) return stat_byte(a - NRW);
        return 8'h00;
    endfunction

    function automatic logic [7:0] pat(int i);
        return 8'((i * 37 + 5) & 8'hff);
    endfunction

    initial for (int i = 0; i < NRW; i++) begin
        rf[i]    = 8'hA0 + 8'(i);
        model[i] = 8'hA0 + 8'(i);
    end

    always @(posedge clk) if (!rst && wr_en) begin
        wr_cnt <= wr_cnt + 1;
        if (wr_addr < 8'(NRW)) rf[wr_addr[4:0]] <= wr_data;
    end

    i2c_regbank_slave u_i2c_regbank_slave (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (h_scl),
        .sda_i      (sda_line),
        .sda_pull_o (sda_pull),
        .wr_en_o    (wr_en),
        .wr_addr_o  (wr_addr),
        .wr_data_o  (wr_data),
        .rd_addr_o  (rd_addr),
        .rd_data_i  (rd_data),
        .status_i   (status)
    );

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        h_sda = 1'b1; tick(Q);
        h_scl = 1'b1; tick(Q);
        h_sda = 1'b0; tick(Q);
        h_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        h_sda = 1'b0; tick(Q);
        h_scl = 1'b1; tick(Q);
        h_sda = 1'b1; tick(2*Q);
    endtask

    task automatic clk_bit(input logic b, output logic s);
        h_sda = b;    tick(Q);
        h_scl = 1'b1; tick(Q);
        s = sda_line; tick(Q);
        h_scl = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        acked = ~s;
    endtask

    task automatic recv_byte(input logic ack, output logic [7:0] v);
        logic s;
        v = '0;
        for (int i = 0; i < 8; i++) begin
            clk_bit(1'b1, s);
            v = {v[6:0], s};
        end
        clk_bit(~ack, s);
    endtask

    task automatic set_ptr(logic [7:0] p);
        logic a;
        bus_start();
        send_byte(8'h24, a); check("R3 addr ack", 8'(a), 8'h1);
        send_byte(p, a);     check("R3 ptr ack", 8'(a), 8'h1);
        bus_stop();
    endtask

    initial begin
        repeat (40) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 8'h1, 8'h0);
        end
    end

    initial begin : wd
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 8'h0, 8'h1);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic a;
        logic [7:0] v;
        int base;
        tick(5);
        rst = 1'b0;
        tick(3);
        done = 1'b1;

        // R1: released outputs and pointer at 00h
        check("R1 sda released", 8'(sda_pull), 8'h0);
        check("R1 no strobe", 8'(wr_en), 8'h0);
        bus_start();
        send_byte(8'h25, a); check("R1 read addr ack", 8'(a), 8'h1);
        recv_byte(1'b0, v);  check("R1 pointer zero read", v, exp_read(0));
        bus_stop();

        // R3: burst write of every writable register
        base = wr_cnt;
        bus_start();
        send_byte(8'h24, a); check("R3 addr ack", 8'(a), 8'h1);
        send_byte(8'h00, a); check("R3 ptr ack", 8'(a), 8'h1);
        for (int i = 0; i < NRW; i++) begin
            send_byte(pat(i), a);
            model[i] = pat(i);
            check("R3 data ack", 8'(a), 8'h1);
        end
        bus_stop();
        check("R3 strobe count", 8'(wr_cnt - base), 8'(NRW));

        // R5 R6 R7 R8: read sweep over writable, status and unmapped space
        set_ptr(8'h00);
        bus_start();
        send_byte(8'h25, a); check("R5 read addr ack", 8'(a), 8'h1);
        for (int i = 0; i < NRW + NST + 3; i++) begin
            recv_byte(i != NRW + NST + 2, v);
            if (i < NRW)            check("R5 reg read", v, exp_read(i));
            else if (i < NRW + NST) check("R6 status read", v, exp_read(i));
            else                    check("R7 unmapped read", v, 8'h00);
        end
        // R8: after host NACK the slave stays off the line
        for (int i = 0; i < 9; i++) begin
            clk_bit(1'b1, a);
            check("R8 released after nack", 8'(a), 8'h1);
        end
        bus_stop();

        // R4: writes crossing into read-only space
        base = wr_cnt;
        bus_start();
        send_byte(8'h24, a); check("R4 addr ack", 8'(a), 8'h1);
        send_byte(8'h1D, a); check("R4 ptr ack", 8'(a), 8'h1);
        for (int i = 0; i < 4; i++) begin
            send_byte(8'h5A + 8'(i), a);
            check("R4 data ack", 8'(a), 8'h1);
        end
        bus_stop();
        model[29] = 8'h5A;
        model[30] = 8'h5B;
        check("R4 strobes only below 1Fh", 8'(wr_cnt - base), 8'h2);

        // R11: pointer continues at 21h after stop
        bus_start();
        send_byte(8'h25, a); check("R11 read addr ack", 8'(a), 8'h1);
        recv_byte(1'b0, v);  check("R11 pointer kept", v, exp_read(8'h21));
        bus_stop();
        set_ptr(8'h1D);
        bus_start();
        send_byte(8'h25, a);
        recv_byte(1'b1, v);  check("R4 reg 1Dh", v, exp_read(29));
        recv_byte(1'b0, v);  check("R4 reg 1Eh", v, exp_read(30));
        bus_stop();

        // R2: every other address byte is ignored
        base = wr_cnt;
        for (int ad = 0; ad < 256; ad++) begin
            if (ad == 8'h24 || ad == 8'h25) continue;
            bus_start();
            send_byte(8'(ad), a);
            check("R2 no ack", 8'(a), 8'h0);
            if (ad == 8'h26) begin
                send_byte(8'h00, a); check("R2 ignored byte", 8'(a), 8'h0);
                send_byte(8'h55, a); check("R2 ignored byte", 8'(a), 8'h0);
            end
            bus_stop();
        end
        check("R2 no writes", 8'(wr_cnt - base), 8'h0);

        // R9: stop in the middle of a data byte
        base = wr_cnt;
        bus_start();
        send_byte(8'h24, a);
        send_byte(8'h05, a);
        for (int i = 0; i < 4; i++) clk_bit(1'b0, a);
        bus_stop();
        check("R9 sda released", 8'(sda_pull), 8'h0);
        check("R9 no partial write", 8'(wr_cnt - base), 8'h0);
        set_ptr(8'h05);
        bus_start();
        send_byte(8'h25, a);
        recv_byte(1'b0, v);  check("R9 reg unchanged", v, exp_read(5));
        bus_stop();

        // R10: repeated start between pointer set and read
        bus_start();
        send_byte(8'h24, a);
        send_byte(8'h20, a);
        bus_start();
        send_byte(8'h25, a); check("R10 read addr ack", 8'(a), 8'h1);
        recv_byte(1'b0, v);  check("R10 status via restart", v, exp_read(8'h20));
        bus_stop();

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule